// File: doc/BRIEF.md
# Dual-Context Expansion RAM Bank Mapper

This block decodes addresses and switches banks for an expansion module that plugs into the cartridge slot of an 8-bit console. The console bus is shared by the CPU and a video DMA engine. When the engine holds the halt line asserted, it owns the bus. The block places a 32KB SRAM behind two 8KB windows, at 0x4000-0x5FFF and 0x6000-0x7FFF. Each window can show any of the four 8KB SRAM segments.

The block keeps two sets of window-to-segment registers: one applies to CPU cycles and the other to video-engine cycles. The halt line picks which set forms the SRAM upper address. The engine can therefore scan one segment while the CPU fills another segment through the same window.

The block also produces chip selects for a fixed save-data ROM, a fixed save-data RAM and a 16-byte sound-chip window. It holds a small control register bank. An enable register gates the expansion RAM and the sound chip, and both gates come out of reset closed, so ordinary cartridges run unaffected. The block must leave alone the console's own RAM at 0x0480 and its mirror at 0x0580.

Top module: `dual_ctx_bank_map`

## Requirements
- R1: After reset the enable register (0x0470) reads 0x00. The CPU window 0/1 slots (0x0471/0x0472) read 0 and 1, and the video window 0/1 slots (0x0473/0x0474) read 0 and 1.
- R2: `rom_ce` is high exactly for addresses 0x3000-0x3FFF, whatever the enable register holds.
- R3: `nvram_ce` is high exactly for addresses 0x1000-0x17FF, whatever the enable register holds.
- R4: `snd_ce` is high only for 0x0450-0x045F, and only while bit 1 of the enable register is set.
- R5: `sram_ce` is high only for 0x4000-0x7FFF, and only while bit 0 of the enable register is set.
- R6: With halt low, `sram_addr` = {segment from the CPU slot of the addressed window, addr[12:0]}. Address bit 13 picks window 1.
- R7: With halt high, `sram_addr` takes its segment from the video slot of the addressed window.
- R8: `sram_we` is high only when `sram_ce` is high, `rw_n` is 0 (write) and halt is low.
- R9: A control write stores wr_data[1:0] into the slot at 0x0470-0x0474 on the rising clock edge when `cyc_valid` is 1, `rw_n` is 0 and halt is low. A write made while halt is high changes nothing.
- R10: A CPU read of 0x0470-0x0474 (rw_n=1, halt low) drives `rd_oe` high, with the slot value on `rd_data[1:0]` and zeros above it. Otherwise `rd_oe` is low and `rd_data` is 0.
- R11: At most one select (`rom_ce`, `nvram_ce`, `snd_ce`, `sram_ce`, `rd_oe`) is high at a time. None is high for 0x0480-0x05FF, 0x0475-0x047F, or any other address outside the ranges above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | 16 | Console address bus |
| rw_n | input | 1 | 1 = read, 0 = write |
| halt | input | 1 | High while the video engine owns the bus |
| cyc_valid | input | 1 | Qualifies a bus cycle for control writes |
| wr_data | input | 8 | Data from the CPU for control writes |
| rd_data | output | 8 | Control read data, 0 when not driving |
| rd_oe | output | 1 | Drive enable for rd_data |
| sram_addr | output | 15 | SRAM address {segment, offset} |
| sram_ce | output | 1 | SRAM chip select |
| sram_we | output | 1 | SRAM write enable |
| rom_ce | output | 1 | Save-data ROM select |
| nvram_ce | output | 1 | Save-data RAM select |
| snd_ce | output | 1 | Sound-chip window select |

## Verification
The assertions assume that `addr`, `rw_n`, `halt` and `cyc_valid` stay constant through each clock cycle. They also assume the video engine never writes, so it never puts rw_n at 0 while it holds halt high. The bench changes every input only on the falling edge and holds it for at least one full cycle. It raises halt together with a write only in the single scenario that proves such writes are ignored. The bench reads the selects partway through the low phase, after the combinational decode has settled.

// File: rtl/bmap_pkg.sv
package bmap_pkg;
  localparam int unsigned SEG_CNT = 4;
  localparam int unsigned SEG_W   = $clog2(SEG_CNT);
  localparam int unsigned WIN_CNT = 2;
  localparam int unsigned WIN_W   = $clog2(WIN_CNT);
  localparam int unsigned CTX_CNT = 2;
  localparam int unsigned SLOT_CNT = CTX_CNT * WIN_CNT;
  localparam int unsigned OFF_W   = 13;
  localparam int unsigned IDX_W   = 3;

  typedef enum logic [IDX_W-1:0] {
    SLOT_ENABLE = 3'd0,
    SLOT_CPU_W0 = 3'd1,
    SLOT_CPU_W1 = 3'd2,
    SLOT_VID_W0 = 3'd3,
    SLOT_VID_W1 = 3'd4
  } ctl_slot_e;

  typedef enum logic {CTX_CPU = 1'b0, CTX_VID = 1'b1} ctx_e;

  typedef struct packed {
    logic rom;
    logic nvram;
    logic snd;
    logic ram;
    logic ctl;
  } sel_t;
endpackage

// File: rtl/bmap_decode.sv
module bmap_decode
  import bmap_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic [AW-1:0]      addr,
  input  logic               ram_en,
  input  logic               snd_en,
  output sel_t               sel,
  output logic [WIN_W-1:0]   win,
  output logic [IDX_W-1:0]   slot
);
  localparam logic [AW-1:0] ROM_LO  = AW'(16'h3000);
  localparam logic [AW-1:0] ROM_HI  = AW'(16'h3FFF);
  localparam logic [AW-1:0] NV_LO   = AW'(16'h1000);
  localparam logic [AW-1:0] NV_HI   = AW'(16'h17FF);
  localparam logic [AW-1:0] SND_LO  = AW'(16'h0450);
  localparam logic [AW-1:0] SND_HI  = AW'(16'h045F);
  localparam logic [AW-1:0] CTL_LO  = AW'(16'h0470);
  localparam logic [AW-1:0] CTL_HI  = AW'(16'h0470 + SLOT_CNT);
  localparam logic [AW-1:0] RAM_LO  = AW'(16'h4000);
  localparam logic [AW-1:0] RAM_HI  = AW'(16'h7FFF);

  function automatic logic in_span(input logic [AW-1:0] a,
                                   input logic [AW-1:0] lo,
                                   input logic [AW-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  logic [AW-1:0] ctl_off;

  always_comb begin
    sel.rom   = in_span(addr, ROM_LO, ROM_HI);
    sel.nvram = in_span(addr, NV_LO, NV_HI);
    sel.snd   = snd_en && in_span(addr, SND_LO, SND_HI);
    sel.ram   = ram_en && in_span(addr, RAM_LO, RAM_HI);
    sel.ctl   = in_span(addr, CTL_LO, CTL_HI);
  end

  assign ctl_off = addr - CTL_LO;
  assign slot    = ctl_off[IDX_W-1:0];
  assign win     = addr[OFF_W +: WIN_W];
endmodule

// File: rtl/bmap_regs.sv
module bmap_regs
  import bmap_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_stb,
  input  logic [IDX_W-1:0]                 slot,
  input  logic [DW-1:0]                    wr_data,
  output logic [1:0]                       en_q,
  output logic [SLOT_CNT-1:0][SEG_W-1:0]   map_q,
  output logic [DW-1:0]                    rd_val
);
  logic unused_hi;
  assign unused_hi = ^wr_data[DW-1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (wr_stb && slot == SLOT_ENABLE) begin
      en_q <= wr_data[1:0];
    end
  end

  for (genvar s = 0; s < SLOT_CNT; s++) begin : g_slot
    localparam logic [SEG_W-1:0] RST_SEG = SEG_W'(s % WIN_CNT);
    localparam logic [IDX_W-1:0] MY_IDX  = IDX_W'(s + 1);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        map_q[s] <= RST_SEG;
      end else if (wr_stb && slot == MY_IDX) begin
        map_q[s] <= wr_data[SEG_W-1:0];
      end
    end
  end

  always_comb begin
    rd_val = '0;
    if (slot == SLOT_ENABLE) begin
      rd_val[1:0] = en_q;
    end else begin
      for (int s = 0; s < SLOT_CNT; s++) begin
        if (slot == IDX_W'(s + 1)) rd_val[SEG_W-1:0] = map_q[s];
      end
    end
  end
endmodule

// File: rtl/bmap_segsel.sv
module bmap_segsel
  import bmap_pkg::*;
(
  input  logic [SLOT_CNT-1:0][SEG_W-1:0] map_q,
  input  logic                           halt,
  input  logic [WIN_W-1:0]               win,
  output logic [SEG_W-1:0]               seg
);
  ctx_e ctx;
  logic [CTX_CNT-1:0][SEG_W-1:0] per_ctx;

  assign ctx = halt ? CTX_VID : CTX_CPU;

  for (genvar c = 0; c < CTX_CNT; c++) begin : g_ctx
    assign per_ctx[c] = map_q[c*WIN_CNT + int'(win)];
  end

  assign seg = per_ctx[ctx];
endmodule

// File: rtl/dual_ctx_bank_map.sv
module dual_ctx_bank_map
  import bmap_pkg::*;
#(
  parameter int unsigned ABUS_W = 16,
  parameter int unsigned DBUS_W = 8,
  localparam int unsigned SA_W  = SEG_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ABUS_W-1:0] addr,
  input  logic              rw_n,
  input  logic              halt,
  input  logic              cyc_valid,
  input  logic [DBUS_W-1:0] wr_data,
  output logic [DBUS_W-1:0] rd_data,
  output logic              rd_oe,
  output logic [SA_W-1:0]   sram_addr,
  output logic              sram_ce,
  output logic              sram_we,
  output logic              rom_ce,
  output logic              nvram_ce,
  output logic              snd_ce
);
  sel_t                          sel;
  logic [WIN_W-1:0]              win;
  logic [IDX_W-1:0]              slot;
  logic [1:0]                    en_q;
  logic [SLOT_CNT-1:0][SEG_W-1:0] map_q;
  logic [SLOT_CNT*SEG_W-1:0]     map_flat;
  logic [DBUS_W-1:0]             rd_val;
  logic [SEG_W-1:0]              seg;
  logic                          cpu_owns;
  logic                          wr_stb;

  assign cpu_owns = ~halt;
  assign wr_stb   = cyc_valid & ~rw_n & cpu_owns & sel.ctl;
  assign map_flat = map_q;

  bmap_decode #(.AW(ABUS_W)) u_dec (
    .addr   (addr),
    .ram_en (en_q[0]),
    .snd_en (en_q[1]),
    .sel    (sel),
    .win    (win),
    .slot   (slot)
  );

  bmap_regs #(.DW(DBUS_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_stb  (wr_stb),
    .slot    (slot),
    .wr_data (wr_data),
    .en_q    (en_q),
    .map_q   (map_q),
    .rd_val  (rd_val)
  );

  bmap_segsel u_seg (
    .map_q (map_q),
    .halt  (halt),
    .win   (win),
    .seg   (seg)
  );

  assign sram_addr = {seg, addr[OFF_W-1:0]};
  assign sram_ce   = sel.ram;
  assign sram_we   = sel.ram & ~rw_n & cpu_owns;
  assign rom_ce    = sel.rom;
  assign nvram_ce  = sel.nvram;
  assign snd_ce    = sel.snd;
  assign rd_oe     = sel.ctl & rw_n & cpu_owns;
  assign rd_data   = rd_oe ? rd_val : '0;
endmodule

// File: rtl/dual_ctx_bank_map_chk.sv
module dual_ctx_bank_map_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] addr,
  input logic        rw_n,
  input logic        halt,
  input logic        sram_ce,
  input logic        sram_we,
  input logic        rom_ce,
  input logic        nvram_ce,
  input logic        snd_ce,
  input logic        rd_oe,
  input logic [1:0]  en_q,
  input logic [7:0]  map_flat
);
  assert_rom_span_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rom_ce == (addr[15:12] == 4'h3));

  assert_nv_span_R3: assert property (@(posedge clk) disable iff (!rst_n)
    nvram_ce == (addr[15:11] == 5'b00010));

  assert_snd_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    snd_ce |-> (en_q[1] && addr[15:4] == 12'h045));

  assert_ram_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sram_ce |-> (en_q[0] && addr[15:14] == 2'b01));

  assert_we_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sram_we |-> (sram_ce && !rw_n && !halt));

  assert_halt_nowrite_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> ($stable(en_q) && $stable(map_flat)));

  assert_oe_owner_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_oe |-> (rw_n && !halt));

  assert_one_sel_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_ce, nvram_ce, snd_ce, sram_ce, rd_oe}));

  assert_riot_free_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (addr >= 16'h0480 && addr <= 16'h05FF) |->
      !(rom_ce || nvram_ce || snd_ce || sram_ce || rd_oe));
endmodule

bind dual_ctx_bank_map dual_ctx_bank_map_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .addr     (addr),
  .rw_n     (rw_n),
  .halt     (halt),
  .sram_ce  (sram_ce),
  .sram_we  (sram_we),
  .rom_ce   (rom_ce),
  .nvram_ce (nvram_ce),
  .snd_ce   (snd_ce),
  .rd_oe    (rd_oe),
  .en_q     (en_q),
  .map_flat (map_flat)
);

// File: tb/dual_ctx_bank_map_tb_top.sv
module dual_ctx_bank_map_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        rw_n = 1'b1;
  logic        halt = 1'b0;
  logic        cyc_valid = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic        rd_oe;
  logic [14:0] sram_addr;
  logic        sram_ce, sram_we, rom_ce, nvram_ce, snd_ce;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_ctx_bank_map dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rw_n(rw_n), .halt(halt),
    .cyc_valid(cyc_valid), .wr_data(wr_data), .rd_data(rd_data),
    .rd_oe(rd_oe), .sram_addr(sram_addr), .sram_ce(sram_ce),
    .sram_we(sram_we), .rom_ce(rom_ce), .nvram_ce(nvram_ce),
    .snd_ce(snd_ce)
  );

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // selects packed as {rom, nvram, snd, sram, oe}
  function automatic logic [4:0] sels();
    return {rom_ce, nvram_ce, snd_ce, sram_ce, rd_oe};
  endfunction

  task automatic drive(input logic [15:0] a, input logic r, input logic h);
    @(negedge clk);
    addr = a; rw_n = r; halt = h; cyc_valid = 1'b0;
    #1;
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d,
                           input logic h);
    @(negedge clk);
    addr = a; rw_n = 1'b0; halt = h; wr_data = d; cyc_valid = 1'b1;
    @(negedge clk);
    cyc_valid = 1'b0; rw_n = 1'b1; halt = 1'b0;
    #1;
  endtask

  task automatic read_ctl(input string req, input logic [15:0] a,
                          input logic [7:0] exp);
    drive(a, 1'b1, 1'b0);
    check(req, {31'd0, rd_oe}, 32'd1);
    check(req, {24'd0, rd_data}, {24'd0, exp});
  endtask

  task automatic t_reset();
    read_ctl("R1 enable reset", 16'h0470, 8'h00);
    read_ctl("R1 cpu w0 reset", 16'h0471, 8'h00);
    read_ctl("R1 cpu w1 reset", 16'h0472, 8'h01);
    read_ctl("R1 vid w0 reset", 16'h0473, 8'h00);
    read_ctl("R1 vid w1 reset", 16'h0474, 8'h01);
    drive(16'h4000, 1'b1, 1'b0);
    check("R5 ram off at reset", {27'd0, sels()}, 32'd0);
    drive(16'h0455, 1'b1, 1'b0);
    check("R4 snd off at reset", {27'd0, sels()}, 32'd0);
  endtask

  task automatic t_fixed();
    drive(16'h3000, 1'b1, 1'b0); check("R2 rom low",  {27'd0, sels()}, 32'h10);
    drive(16'h3FFF, 1'b1, 1'b0); check("R2 rom high", {27'd0, sels()}, 32'h10);
    drive(16'h2FFF, 1'b1, 1'b0); check("R2 rom below", {27'd0, sels()}, 32'h00);
    drive(16'h1000, 1'b1, 1'b0); check("R3 nv low",  {27'd0, sels()}, 32'h08);
    drive(16'h17FF, 1'b1, 1'b0); check("R3 nv high", {27'd0, sels()}, 32'h08);
    drive(16'h1800, 1'b1, 1'b0); check("R3 nv above", {27'd0, sels()}, 32'h00);
  endtask

  task automatic t_enables();
    bus_write(16'h0470, 8'h03, 1'b0);
    read_ctl("R9 enable stored", 16'h0470, 8'h03);
    drive(16'h6000, 1'b1, 1'b0); check("R5 ram on",  {27'd0, sels()}, 32'h02);
    drive(16'h8000, 1'b1, 1'b0); check("R5 ram above", {27'd0, sels()}, 32'h00);
    drive(16'h045F, 1'b1, 1'b0); check("R4 snd top", {27'd0, sels()}, 32'h04);
    drive(16'h0450, 1'b1, 1'b0); check("R4 snd base", {27'd0, sels()}, 32'h04);
    drive(16'h0460, 1'b1, 1'b0); check("R4 snd past", {27'd0, sels()}, 32'h00);
    drive(16'h3800, 1'b1, 1'b0); check("R2 rom with enables", {27'd0, sels()}, 32'h10);
  endtask

  task automatic t_cpu_map();
    bus_write(16'h0471, 8'h03, 1'b0);
    bus_write(16'h0472, 8'h02, 1'b0);
    drive(16'h5ABC, 1'b1, 1'b0);
    check("R6 cpu w0 seg3", {17'd0, sram_addr}, 32'h7ABC);
    drive(16'h7001, 1'b1, 1'b0);
    check("R6 cpu w1 seg2", {17'd0, sram_addr}, 32'h5001);
  endtask

  task automatic t_vid_map();
    bus_write(16'h0473, 8'h01, 1'b0);
    bus_write(16'h0474, 8'h00, 1'b0);
    drive(16'h4123, 1'b1, 1'b1);
    check("R7 vid w0 seg1", {17'd0, sram_addr}, 32'h2123);
    drive(16'h6123, 1'b1, 1'b1);
    check("R7 vid w1 seg0", {17'd0, sram_addr}, 32'h0123);
    drive(16'h4123, 1'b1, 1'b0);
    check("R6 cpu still seg3", {17'd0, sram_addr}, 32'h6123);
  endtask

  task automatic t_we();
    drive(16'h4000, 1'b0, 1'b0); check("R8 cpu write", {31'd0, sram_we}, 32'd1);
    drive(16'h4000, 1'b1, 1'b0); check("R8 read no we", {31'd0, sram_we}, 32'd0);
    drive(16'h1000, 1'b0, 1'b0); check("R8 we outside", {31'd0, sram_we}, 32'd0);
    bus_write(16'h0470, 8'h02, 1'b0);
    drive(16'h4000, 1'b0, 1'b0); check("R8 ram disabled", {31'd0, sram_we}, 32'd0);
    bus_write(16'h0470, 8'h03, 1'b0);
  endtask

  task automatic t_halt_write();
    bus_write(16'h0471, 8'h00, 1'b1);
    read_ctl("R9 halt write ignored", 16'h0471, 8'h03);
    drive(16'h4000, 1'b0, 1'b1);
    check("R8 halt blocks we", {31'd0, sram_we}, 32'd0);
    drive(16'h0471, 1'b1, 1'b1);
    check("R10 no oe under halt", {31'd0, rd_oe}, 32'd0);
    check("R10 data zero under halt", {24'd0, rd_data}, 32'd0);
  endtask

  task automatic t_unclaimed();
    drive(16'h0480, 1'b1, 1'b0); check("R11 0480", {27'd0, sels()}, 32'd0);
    drive(16'h04FF, 1'b1, 1'b0); check("R11 04FF", {27'd0, sels()}, 32'd0);
    drive(16'h0580, 1'b1, 1'b0); check("R11 0580", {27'd0, sels()}, 32'd0);
    drive(16'h05FF, 1'b1, 1'b0); check("R11 05FF", {27'd0, sels()}, 32'd0);
    drive(16'h0475, 1'b1, 1'b0); check("R11 0475", {27'd0, sels()}, 32'd0);
    check("R10 idle data", {24'd0, rd_data}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fixed();
    t_enables();
    t_cpu_map();
    t_vid_map();
    t_we();
    t_halt_write();
    t_unclaimed();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule